// File: doc/BRIEF.md
# Asynchronous serial receiver with error flags

This block receives asynchronous serial characters on a single input line. A strobe at sixteen times the bit rate paces it. Once receive is enabled and the line has been seen at its idle level, a falling edge starts a frame. The start bit is confirmed by a sample near its middle. The block then samples each data bit, the optional parity bit and one or two stop bits at the middle of their bit periods, and collects the character in a shift register.

At the last stop bit the character moves into a read buffer. On that cycle the block raises a one-cycle receive interrupt and updates its framing and parity flags. A read strobe empties the buffer. A request-to-send output, active low, asks the far end to send only while the buffer is empty.

Character length, parity mode, stop-bit count, bit order, data-only inversion and whole-line polarity inversion are static configuration inputs. They are held steady while a frame is in flight. An overrun is declared when the buffer is still unread at the bit before the last stop bit of the next frame. That frame is then dropped without an interrupt.

Top module: `uart_rx_err`

## Requirements
- R1: A frame starts only while rx_en is high, after the line has been seen idle (high after pin inversion), on a low level at a tick. The start is kept only if the line is still low at the 8th tick after detection. Otherwise the receiver goes back to idle and produces no character. Dropping rx_en aborts a frame.
- R2: cfg_len selects the character length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 give 9 bits. cfg_par_en adds one parity bit after the data bits. cfg_stop2 expects two stop bits instead of one. rd_data holds the character right-aligned, with zeros above its length.
- R3: With cfg_msb_first low, the first data bit received lands in rd_data[0]. With cfg_msb_first high, it lands in rd_data[len-1].
- R4: cfg_data_inv inverts the data and parity bits but not the start or stop bits. cfg_pin_inv inverts the whole line, so the idle level at rxd becomes low.
- R5: frm_err is written only on the cycle rx_irq is high. It is set when any expected stop-bit sample is low and cleared otherwise.
- R6: par_err is written only on the cycle rx_irq is high. It is set when parity is enabled and the count of ones across the character and parity bits is not even (cfg_par_odd=0) or not odd (cfg_par_odd=1). It is cleared otherwise.
- R7: If the buffer is still full when the bit before the last stop bit of a frame is sampled, ovr_err is set at that sample. That frame is then not transferred, rx_irq stays low, and frm_err and par_err keep their values.
- R8: A one-cycle rd_stb empties the buffer and clears ovr_err.
- R9: err_sum is high whenever any of ovr_err, frm_err or par_err is high.
- R10: rts_n is low exactly when rx_en is high and the buffer is empty.
- R11: rx_irq is a one-cycle pulse on the cycle the character is written into rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial input line |
| cfg_len | input | 2 | Character length: 0 gives 7 bits, 1 gives 8 bits, 2 or 3 give 9 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_stop2 | input | 1 | Two stop bits expected |
| cfg_msb_first | input | 1 | Most significant bit is received first |
| cfg_data_inv | input | 1 | Invert data and parity bits |
| cfg_pin_inv | input | 1 | Invert the whole line |
| rd_stb | input | 1 | Read strobe that empties the buffer |
| rd_data | output | 9 | Received character |
| rx_irq | output | 1 | Receive interrupt pulse |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions assume that the configuration inputs stay still while a frame is in progress. They also assume that rd_stb never lands on the same cycle as the overrun sample or the final stop sample. The bench changes configuration only between frames, with the line held idle. It issues reads only after a frame has fully ended. Each bit is held for exactly sixteen ticks, so every mid-bit sample sees a settled level.

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_msb_first,
  input  logic       cfg_data_inv,
  input  logic       cfg_pin_inv,
  input  logic       rd_stb,
  output logic [8:0] rd_data,
  output logic       rx_irq,
  output logic       ovr_err,
  output logic       frm_err,
  output logic       par_err,
  output logic       err_sum,
  output logic       rts_n
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] END = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic          s1, s2, armed;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic          sidx;
  logic [8:0]    sh;
  logic          pacc, sbad, fovr, full;

  logic [3:0] nbits;
  logic [8:0] mask, chr;
  logic       line, bitv, smp, pre_last, last_stop;

  assign nbits = (cfg_len == 2'd0) ? 4'd7 : (cfg_len == 2'd1) ? 4'd8 : 4'd9;
  assign mask  = 9'h1ff >> (4'd9 - nbits);
  assign chr   = cfg_msb_first ? (sh & mask) : (sh >> (4'd9 - nbits));
  assign line  = s2;
  assign bitv  = line ^ cfg_data_inv;
  assign smp   = tick16 && cnt == END && st != S_IDLE && st != S_START;
  assign pre_last = (st == S_DATA && bidx == nbits - 4'd1 && !cfg_par_en && !cfg_stop2)
                 || (st == S_PAR && !cfg_stop2)
                 || (st == S_STOP && cfg_stop2 && !sidx);
  assign last_stop = st == S_STOP && (sidx || !cfg_stop2);

  assign err_sum = ovr_err | frm_err | par_err;
  assign rts_n   = !(rx_en && !full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd ^ cfg_pin_inv;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      armed   <= 1'b0;
      cnt     <= '0;
      bidx    <= '0;
      sidx    <= 1'b0;
      sh      <= '0;
      pacc    <= 1'b0;
      sbad    <= 1'b0;
      fovr    <= 1'b0;
      full    <= 1'b0;
      rd_data <= '0;
      rx_irq  <= 1'b0;
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (rd_stb) begin
        full    <= 1'b0;
        ovr_err <= 1'b0;
      end
      if (!rx_en) begin
        st    <= S_IDLE;
        armed <= 1'b0;
      end else if (tick16) begin
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (line) armed <= 1'b1;
            else if (armed) st <= S_START;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              bidx <= '0;
              pacc <= 1'b0;
              sbad <= 1'b0;
              fovr <= 1'b0;
              st   <= line ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            cnt <= cnt + 1'b1;
            if (cnt == END) begin
              if (pre_last && full) begin
                ovr_err <= 1'b1;
                fovr    <= 1'b1;
              end
              case (st)
                S_DATA: begin
                  sh   <= cfg_msb_first ? {sh[7:0], bitv} : {bitv, sh[8:1]};
                  pacc <= pacc ^ bitv;
                  sidx <= 1'b0;
                  if (bidx == nbits - 4'd1) st <= cfg_par_en ? S_PAR : S_STOP;
                  else bidx <= bidx + 4'd1;
                end
                S_PAR: begin
                  pacc <= pacc ^ bitv;
                  st   <= S_STOP;
                end
                default: begin
                  if (last_stop) begin
                    st    <= S_IDLE;
                    armed <= 1'b0;
                    if (!fovr) begin
                      rd_data <= chr;
                      full    <= 1'b1;
                      rx_irq  <= 1'b1;
                      frm_err <= sbad | !line;
                      par_err <= cfg_par_en && (pacc != cfg_par_odd);
                    end
                  end else begin
                    sbad <= sbad | !line;
                    sidx <= 1'b1;
                  end
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !rx_en) |=> st == S_IDLE);

  p_frm_at_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frm_err) |-> rx_irq);

  p_par_at_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_err) |-> rx_irq);

  p_ovr_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> !rx_irq && $stable(rd_data));

  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(smp && pre_last)) |=> !ovr_err);

  p_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err || frm_err || par_err) |-> err_sum);

  p_rts_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rts_n);

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
endmodule

// File: tb/uart_rx_err_tb.sv
module uart_rx_err_tb;
  logic clk = 0, rst_n = 0, tick16 = 0, rx_en = 0, rxd = 1, rd_stb = 0;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_msb_first = 0;
  logic cfg_data_inv = 0, cfg_pin_inv = 0;
  logic [8:0] rd_data;
  logic rx_irq, ovr_err, frm_err, par_err, err_sum, rts_n;
  int total = 0, bad = 0;
  logic [10:0] q[$];

  uart_rx_err u_dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_msb_first(cfg_msb_first), .cfg_data_inv(cfg_data_inv),
    .cfg_pin_inv(cfg_pin_inv), .rd_stb(rd_stb), .rd_data(rd_data), .rx_irq(rx_irq),
    .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err), .err_sum(err_sum), .rts_n(rts_n));

  always #5 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    tick16 = 1;
    @(negedge clk);
    tick16 = 0;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rx_irq) begin
    if (q.size() == 0) check(0, "R11 unexpected irq (R7 overrun drop)", 1, 0);
    else begin
      logic [10:0] e;
      e = q.pop_front();
      check(rd_data == e[8:0], "R2 R3 R4 data", rd_data, e[8:0]);
      check(frm_err == e[9], "R5 frm_err", frm_err, e[9]);
      check(par_err == e[10], "R6 par_err", par_err, e[10]);
      check(err_sum == (e[9] | e[10] | ovr_err), "R9 err_sum", err_sum, e[9] | e[10]);
      check(rts_n == 1'b1, "R10 rts_n full", rts_n, 1);
    end
  end

  task automatic put(input logic b, input int n = 64);
    rxd = b ^ cfg_pin_inv;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] ch, input logic bpar, input logic bstop, input logic expect_irq);
    int n;
    logic [8:0] m;
    logic p;
    n = (cfg_len == 0) ? 7 : (cfg_len == 1) ? 8 : 9;
    m = ch & (9'h1ff >> (9 - n));
    p = (^m) ^ cfg_par_odd;
    if (expect_irq) q.push_back({cfg_par_en & bpar, bstop, m});
    put(0);
    for (int i = 0; i < n; i++) put(m[cfg_msb_first ? n - 1 - i : i] ^ cfg_data_inv);
    if (cfg_par_en) put(p ^ bpar ^ cfg_data_inv);
    put(!bstop);
    if (cfg_stop2) put(1);
    put(1, 32);
  endtask

  task automatic rd;
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    @(negedge clk);
  endtask

  task automatic fmt(input logic [1:0] l, input logic pe, input logic po, input logic s2,
                     input logic mf, input logic di, input logic pi);
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    cfg_msb_first = mf; cfg_data_inv = di; cfg_pin_inv = pi;
    rxd = ~pi;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    #1500000;
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rx_irq == 0 && ovr_err == 0 && frm_err == 0 && par_err == 0, "reset flags", 1, 0);
    check(rts_n == 1, "R10 rts_n disabled", rts_n, 1);
    check(rd_data == 0, "reset rd_data", rd_data, 0);
    send(9'h0a5, 0, 0, 0);
    check(q.size() == 0 && rts_n == 1, "R1 disabled no frame", rts_n, 1);
    rx_en = 1;
    repeat (80) @(negedge clk);
    check(rts_n == 0, "R10 rts_n empty", rts_n, 0);
    send(9'h0a5, 0, 0, 1); rd;
    send(9'h13c, 0, 0, 1); rd;
    check(rts_n == 0, "R8 R10 read empties", rts_n, 0);
    fmt(2'd0, 1, 0, 0, 0, 0, 0);
    send(9'h05a, 0, 0, 1); rd;
    send(9'h07f, 1, 0, 1); rd;
    check(err_sum == 1, "R9 sum after parity error", err_sum, 1);
    send(9'h011, 0, 0, 1); rd;
    check(par_err == 0, "R6 cleared by good frame", par_err, 0);
    fmt(2'd2, 1, 1, 1, 0, 0, 0);
    send(9'h1c3, 0, 0, 1); rd;
    send(9'h155, 1, 0, 1); rd;
    send(9'h0f0, 0, 1, 1); rd;
    send(9'h0e1, 0, 0, 1); rd;
    check(frm_err == 0, "R5 cleared", frm_err, 0);
    fmt(2'd1, 0, 0, 0, 1, 0, 0);
    send(9'h081, 0, 0, 1); rd;
    send(9'h0c4, 0, 0, 1); rd;
    send(9'h0c4, 0, 1, 1); rd;
    fmt(2'd2, 1, 0, 0, 1, 0, 0);
    send(9'h101, 0, 0, 1); rd;
    fmt(2'd1, 1, 0, 0, 0, 1, 0);
    send(9'h036, 0, 0, 1); rd;
    send(9'h036, 1, 0, 1); rd;
    fmt(2'd1, 0, 0, 0, 0, 0, 1);
    send(9'h0d2, 0, 0, 1); rd;
    fmt(2'd1, 1, 1, 0, 1, 1, 1);
    send(9'h0b7, 0, 0, 1); rd;
    fmt(2'd1, 0, 0, 0, 0, 0, 0);
    send(9'h042, 0, 0, 1);
    check(rts_n == 1, "R10 rts_n held while unread", rts_n, 1);
    send(9'h099, 0, 0, 0);
    check(ovr_err == 1 && err_sum == 1, "R7 overrun flagged", ovr_err, 1);
    check(frm_err == 0 && par_err == 0, "R7 frm par kept", frm_err, 0);
    rd;
    check(ovr_err == 0 && rts_n == 0, "R8 read clears overrun", ovr_err, 0);
    put(0, 12);
    put(1, 200);
    check(q.size() == 0, "R1 false start no char", q.size(), 0);
    send(9'h066, 0, 0, 1); rd;
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R11 all frames delivered", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule